// File: doc/BRIEF.md
# Qword Write Steering with Parity

This block takes 64-bit qwords from a host data bus and files them into two stores. The first is a four-entry read buffer whose entries are chosen by the command. The second is a posted write FIFO. A command code on each clock selects the action. The block can store a qword at a fixed buffer location, post a qword to the FIFO, or, for write-back traffic, place the same qword in both stores in one cycle.

Every stored qword carries eight parity bits. Depending on a strap input, these bits are either computed from the data as even parity per byte or copied from the host parity lines. The strap is captured when reset is released and then held until the next reset. Both stores have read ports. The FIFO also has a pop input, an occupancy count and a sticky overflow flag. Draining the stores belongs to downstream logic.

Top module: `qw_steer`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), the FIFO count and overflow flag clear to 0, all four read-buffer entries clear to zero data and zero parity, and the dual-write location pointer returns to 0.
- R2: Command codes 1, 2, 3 and 4 write the host qword into read-buffer location 0, 1, 2 and 3 respectively, and leave the other locations unchanged; the result is readable on the cycle after the edge.
- R3: The parity mode is the value of `par_strap` at the last rising clock edge with `rst_n` low (0 = generate, 1 = pass host parity through). Later changes of the strap have no effect until the next reset.
- R4: In generate mode, stored parity bit i is even parity over data byte i (bits 8i+7..8i), so byte plus parity holds an even number of ones; `host_par` is ignored.
- R5: Command code 5 pushes the host qword onto the posted write FIFO and leaves the read buffer unchanged. Codes 1 to 4 leave the FIFO unchanged.
- R6: Command code 6 writes the same qword and parity into read-buffer location 0 and onto the FIFO in the same cycle, and sets the dual-write pointer to 1.
- R7: Command code 7 writes the qword into read-buffer location given by the dual-write pointer and onto the FIFO, then advances the pointer by one, wrapping from 3 to 0.
- R8: The FIFO is 4 entries deep and returns entries in push order. `wf_pop` removes the head, and `wf_count` gives the number of stored entries.
- R9: A push while the FIFO holds 4 entries is dropped and sets `wf_ovf`, which stays set until reset. A pop while the FIFO is empty has no effect.
- R10: Command code 0 changes neither store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| par_strap | input | 1 | Parity mode strap, captured at reset release |
| cmd | input | 3 | Command code (0 idle, 1-4 store loc 0-3, 5 post, 6 first write-back, 7 next write-back) |
| host_data | input | 64 | Host qword |
| host_par | input | 8 | Host parity, one bit per byte |
| rb_sel | input | 2 | Read-buffer location to read |
| rb_data | output | 64 | Data of selected read-buffer location |
| rb_par | output | 8 | Parity of selected read-buffer location |
| wf_pop | input | 1 | Remove the FIFO head |
| wf_data | output | 64 | FIFO head data |
| wf_par | output | 8 | FIFO head parity |
| wf_count | output | 3 | FIFO occupancy |
| wf_ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
On every cycle, the assertions check the FIFO occupancy bound, that a push into a full FIFO is dropped and raises the sticky overflow flag, that the captured parity mode stays put while out of reset, that dual-write commands grow the occupancy and that idle cycles leave it unchanged. Only the bench scenarios can show the data-level behaviour. These are which location each store command hits, the parity values in both modes, the way the write-back pointer advances and wraps, and FIFO ordering.

// File: rtl/qw_steer_pkg.sv
package qw_steer_pkg;
  localparam int QW_W  = 64;
  localparam int PAR_W = QW_W / 8;

  typedef enum logic [2:0] {
    CMD_IDLE    = 3'd0,
    CMD_ST0     = 3'd1,
    CMD_ST1     = 3'd2,
    CMD_ST2     = 3'd3,
    CMD_ST3     = 3'd4,
    CMD_POST    = 3'd5,
    CMD_WB_HEAD = 3'd6,
    CMD_WB_TAIL = 3'd7
  } cmd_e;

  typedef struct packed {
    logic [QW_W-1:0]  data;
    logic [PAR_W-1:0] par;
  } qw_t;

  // even parity per byte: the parity bit equals the XOR of the byte
  function automatic logic [PAR_W-1:0] byte_even_par(input logic [QW_W-1:0] d);
    logic [PAR_W-1:0] p;
    for (int b = 0; b < PAR_W; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction
endpackage

// File: rtl/qw_par_sel.sv
module qw_par_sel
  import qw_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap,
  input  logic [QW_W-1:0]  data,
  input  logic [PAR_W-1:0] host_par,
  output logic [PAR_W-1:0] par_out,
  output logic             mode
);
  // tracks the strap while in reset, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) mode <= strap;
  end

  assign par_out = mode ? host_par : byte_even_par(data);
endmodule

// File: rtl/qw_rd_buf.sv
module qw_rd_buf
  import qw_steer_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(ENTRIES)-1:0] widx,
  input  qw_t                        din,
  input  logic [$clog2(ENTRIES)-1:0] rsel,
  output qw_t                        dout
);
  localparam int AW = $clog2(ENTRIES);

  qw_t ent [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                     ent[i] <= '0;
      else if (we && widx == AW'(i))  ent[i] <= din;
    end
  end

  assign dout = ent[rsel];
endmodule

// File: rtl/qw_wr_fifo.sv
module qw_wr_fifo
  import qw_steer_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  qw_t                        din,
  output qw_t                        dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  qw_t           mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/qw_steer.sv
module qw_steer
  import qw_steer_pkg::*;
#(
  parameter int WF_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          par_strap,
  input  logic [2:0]                    cmd,
  input  logic [63:0]                   host_data,
  input  logic [7:0]                    host_par,
  input  logic [1:0]                    rb_sel,
  output logic [63:0]                   rb_data,
  output logic [7:0]                    rb_par,
  input  logic                          wf_pop,
  output logic [63:0]                   wf_data,
  output logic [7:0]                    wf_par,
  output logic [$clog2(WF_DEPTH+1)-1:0] wf_count,
  output logic                          wf_ovf
);
  localparam int RB_ENTRIES = 4;
  localparam int RB_AW      = $clog2(RB_ENTRIES);

  cmd_e             cmd_q;
  logic [PAR_W-1:0] sel_par;
  logic             par_mode;
  qw_t              wr_qw, rb_out, wf_out;
  logic             rb_we, fifo_push, fifo_full;
  logic [RB_AW-1:0] rb_idx, wb_ptr;

  assign cmd_q = cmd_e'(cmd);

  qw_par_sel u_par (
    .clk(clk), .rst_n(rst_n), .strap(par_strap), .data(host_data),
    .host_par(host_par), .par_out(sel_par), .mode(par_mode)
  );

  assign wr_qw = '{data: host_data, par: sel_par};

  // command decode: read-buffer write enable/location and FIFO push
  always_comb begin
    rb_we     = 1'b0;
    rb_idx    = '0;
    fifo_push = 1'b0;
    unique case (cmd_q)
      CMD_ST0, CMD_ST1, CMD_ST2, CMD_ST3: begin
        rb_we  = 1'b1;
        rb_idx = RB_AW'(cmd - 3'(CMD_ST0));
      end
      CMD_POST:    fifo_push = 1'b1;
      CMD_WB_HEAD: begin rb_we = 1'b1; fifo_push = 1'b1; end
      CMD_WB_TAIL: begin rb_we = 1'b1; rb_idx = wb_ptr; fifo_push = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    wb_ptr <= '0;
    else if (cmd_q == CMD_WB_HEAD) wb_ptr <= RB_AW'(1);
    else if (cmd_q == CMD_WB_TAIL) wb_ptr <= wb_ptr + 1'b1;
  end

  qw_rd_buf #(.ENTRIES(RB_ENTRIES)) u_rb (
    .clk(clk), .rst_n(rst_n), .we(rb_we), .widx(rb_idx), .din(wr_qw),
    .rsel(rb_sel), .dout(rb_out)
  );

  qw_wr_fifo #(.DEPTH(WF_DEPTH)) u_wf (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(wf_pop), .din(wr_qw),
    .dout(wf_out), .count(wf_count), .full(fifo_full), .ovf(wf_ovf)
  );

  assign rb_data = rb_out.data;
  assign rb_par  = rb_out.par;
  assign wf_data = wf_out.data;
  assign wf_par  = wf_out.par;
endmodule

// File: rtl/qw_steer_chk.sv
module qw_steer_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [2:0]                 cmd,
  input logic                       wf_pop,
  input logic [$clog2(DEPTH+1)-1:0] wf_count,
  input logic                       wf_ovf,
  input logic                       fifo_push,
  input logic                       fifo_full,
  input logic                       par_mode
);
  localparam int CW = $clog2(DEPTH + 1);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wf_count <= CW'(DEPTH));

  assert_drop_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push && fifo_full && !wf_pop) |=> wf_count == CW'(DEPTH));

  assert_ovf_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push && fifo_full) |=> wf_ovf);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wf_ovf |=> wf_ovf);

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(par_mode));

  assert_dual_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[2:1] == 2'b11 && !fifo_full && !wf_pop) |=> wf_count == $past(wf_count) + 1'b1);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd0 && !wf_pop) |=> $stable(wf_count));
endmodule

bind qw_steer qw_steer_chk #(.DEPTH(WF_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .wf_pop(wf_pop), .wf_count(wf_count),
  .wf_ovf(wf_ovf), .fifo_push(fifo_push), .fifo_full(fifo_full), .par_mode(par_mode)
);

// File: tb/qw_steer_tb.sv
`timescale 1ns/1ps
module qw_steer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        par_strap = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [63:0] host_data = '0;
  logic [7:0]  host_par = '0;
  logic [1:0]  rb_sel = '0;
  logic [63:0] rb_data, wf_data;
  logic [7:0]  rb_par, wf_par;
  logic        wf_pop = 1'b0;
  logic [2:0]  wf_count;
  logic        wf_ovf;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  qw_steer u_dut (
    .clk(clk), .rst_n(rst_n), .par_strap(par_strap), .cmd(cmd),
    .host_data(host_data), .host_par(host_par), .rb_sel(rb_sel),
    .rb_data(rb_data), .rb_par(rb_par), .wf_pop(wf_pop), .wf_data(wf_data),
    .wf_par(wf_par), .wf_count(wf_count), .wf_ovf(wf_ovf)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // parity by counting ones per byte
  function automatic logic [7:0] ref_par(input logic [63:0] d);
    logic [7:0] p;
    for (int b = 0; b < 8; b++) begin
      int ones = 0;
      for (int k = 0; k < 8; k++) ones += d[b*8+k];
      p[b] = (ones % 2) == 1;
    end
    return p;
  endfunction

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; par_strap = strap; cmd = 3'd0; wf_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    par_strap = ~strap;
    #1;
  endtask

  task automatic drive(input logic [2:0] c, input logic [63:0] d, input logic [7:0] p);
    @(negedge clk);
    cmd = c; host_data = d; host_par = p;
    @(posedge clk); #1;
    cmd = 3'd0;
  endtask

  task automatic pop1;
    @(negedge clk); wf_pop = 1'b1;
    @(posedge clk); #1; wf_pop = 1'b0;
  endtask

  task automatic rd_rb(input logic [1:0] idx, output logic [63:0] d, output logic [7:0] p);
    rb_sel = idx; #0.5;
    d = rb_data; p = rb_par;
  endtask

  task automatic t_reset;
    logic [63:0] d; logic [7:0] p;
    do_reset(1'b0);
    chk("R1 count", 64'(wf_count), 64'd0);
    chk("R1 ovf", 64'(wf_ovf), 64'd0);
    for (int i = 0; i < 4; i++) begin
      rd_rb(2'(i), d, p);
      chk("R1 rb clear", {d[55:0], p}, 64'd0);
    end
    drive(3'd7, 64'hA5A5_0000_1111_2222, 8'h00);
    rd_rb(2'd0, d, p);
    chk("R1 R7 ptr starts at 0", d, 64'hA5A5_0000_1111_2222);
  endtask

  task automatic t_stores;
    logic [63:0] d; logic [7:0] p;
    do_reset(1'b0);
    for (int k = 0; k < 4; k++) begin
      drive(3'(k + 1), 64'h1000_0000_0000_0001 * (k + 3), 8'hFF);
      rd_rb(2'(k), d, p);
      chk("R2 store loc", d, 64'h1000_0000_0000_0001 * (k + 3));
      chk("R4 gen parity", 64'(p), 64'(ref_par(64'h1000_0000_0000_0001 * (k + 3))));
    end
    for (int k = 0; k < 4; k++) begin
      rd_rb(2'(k), d, p);
      chk("R2 others kept", d, 64'h1000_0000_0000_0001 * (k + 3));
    end
    chk("R5 stores skip fifo", 64'(wf_count), 64'd0);
    drive(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    rd_rb(2'd2, d, p);
    chk("R10 idle keeps rb", d, 64'h1000_0000_0000_0001 * 5);
    chk("R10 idle keeps fifo", 64'(wf_count), 64'd0);
  endtask

  task automatic t_post;
    logic [63:0] d; logic [7:0] p;
    do_reset(1'b0);
    for (int k = 0; k < 3; k++) drive(3'd5, 64'hC0DE_0000_0000_0000 + k, 8'h00);
    chk("R8 count", 64'(wf_count), 64'd3);
    rd_rb(2'd0, d, p);
    chk("R5 post skips rb", d, 64'd0);
    for (int k = 0; k < 3; k++) begin
      chk("R8 order", wf_data, 64'hC0DE_0000_0000_0000 + k);
      chk("R4 fifo parity", 64'(wf_par), 64'(ref_par(64'hC0DE_0000_0000_0000 + k)));
      pop1();
    end
    chk("R8 drained", 64'(wf_count), 64'd0);
    pop1();
    chk("R9 pop empty", 64'(wf_count), 64'd0);
    chk("R9 no ovf", 64'(wf_ovf), 64'd0);
  endtask

  task automatic t_dual;
    logic [63:0] d; logic [7:0] p;
    do_reset(1'b0);
    drive(3'd6, 64'hD000_0000_0000_0000, 8'h00);
    rd_rb(2'd0, d, p);
    chk("R6 rb loc0", d, 64'hD000_0000_0000_0000);
    chk("R6 fifo", wf_data, 64'hD000_0000_0000_0000);
    chk("R6 count", 64'(wf_count), 64'd1);
    for (int k = 1; k < 4; k++) begin
      drive(3'd7, 64'hD000_0000_0000_0000 + k, 8'h00);
      rd_rb(2'(k), d, p);
      chk("R7 rb loc", d, 64'hD000_0000_0000_0000 + k);
    end
    chk("R8 full", 64'(wf_count), 64'd4);
    chk("R9 ovf clear", 64'(wf_ovf), 64'd0);
    drive(3'd7, 64'hD000_0000_0000_0004, 8'h00);
    rd_rb(2'd0, d, p);
    chk("R7 wrap to loc0", d, 64'hD000_0000_0000_0004);
    chk("R9 drop count", 64'(wf_count), 64'd4);
    chk("R9 ovf set", 64'(wf_ovf), 64'd1);
    chk("R9 head kept", wf_data, 64'hD000_0000_0000_0000);
    pop1();
    chk("R9 ovf sticky", 64'(wf_ovf), 64'd1);
    for (int k = 1; k < 4; k++) begin
      chk("R8 dual order", wf_data, 64'hD000_0000_0000_0000 + k);
      pop1();
    end
    chk("R9 dropped not stored", 64'(wf_count), 64'd0);
  endtask

  task automatic t_prop;
    logic [63:0] d; logic [7:0] p;
    do_reset(1'b1);
    drive(3'd3, 64'h0123_4567_89AB_CDEF, 8'h5A);
    rd_rb(2'd2, d, p);
    chk("R3 pass parity", 64'(p), 64'h5A);
    drive(3'd5, 64'h0, 8'hC3);
    chk("R3 pass fifo parity", 64'(wf_par), 64'hC3);
    do_reset(1'b0);
    drive(3'd2, 64'h0123_4567_89AB_CDEF, 8'h5A);
    rd_rb(2'd1, d, p);
    chk("R3 R4 gen after reset", 64'(p), 64'(ref_par(64'h0123_4567_89AB_CDEF)));
  endtask

  initial begin
    t_reset();
    t_stores();
    t_post();
    t_dual();
    t_prop();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule